// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block guards the pins of a SPI port against two drivers fighting over the same wire. It takes the role bit that selects master or slave operation and sets the output enables of the serial clock, MOSI and MISO pads from it. It also watches the slave-select pad. That pad is first passed through a synchronizer. When its level contradicts the selected role, the block latches a fault flag, provided fault detection is enabled.

In slave mode, the contradiction is a deselect (select high) while a transfer is running. In master mode, it is any low level on select, whether or not a transfer is running. While the flag is set in master mode, the block releases the clock and MOSI pads to high impedance and tells the shifter to abort. Software removes the flag in two steps: it reads status while the flag is set, then writes control. An interrupt request follows the flag, gated by an enable.

Top module: `spi_fault_guard`

## Requirements
- R1: With `master_sel`=1 and no fault, `sck_oe`=1, `mosi_oe`=1 and `miso_oe`=0. With `master_sel`=0, `sck_oe`=0, `mosi_oe`=0 and `miso_oe`=1.
- R2: In slave mode with `fault_en`=1, a synchronized `ssel_pin` level of 1 while `xfer_busy`=1 sets `fault_flag`.
- R3: In master mode with `fault_en`=1, a synchronized `ssel_pin` level of 0 sets `fault_flag`, whether or not `xfer_busy` is asserted.
- R4: While `fault_en`=0, `fault_flag` never goes from 0 to 1.
- R5: Dropping `fault_en` does not clear a flag that is already set. Once that flag is cleared, it stays clear for as long as `fault_en` remains 0.
- R6: `fault_flag` clears on a `ctrl_wr` pulse only if a `stat_rd` pulse was seen on an earlier cycle while the flag was set. A `ctrl_wr` without such a read leaves the flag set.
- R7: When a fault condition and a valid clear fall in the same cycle, the flag stays set.
- R8: While `fault_flag`=1 with `master_sel`=1, `sck_oe`=0, `mosi_oe`=0 and `xfer_abort`=1. In every other case `xfer_abort`=0.
- R9: `irq` is 1 exactly when `fault_flag`=1 and `irq_en`=1.
- R10: After a synchronous reset, `fault_flag` is 0 and the synchronized select reads as inactive (1).
- R11: `ssel_pin` passes through two flops. A level applied before clock edge k first affects `fault_flag` at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | Role: 1 = master, 0 = slave |
| fault_en | input | 1 | Enables new setting of the fault flag |
| irq_en | input | 1 | Interrupt enable for the fault flag |
| ssel_pin | input | 1 | Raw slave-select pad level, active low |
| xfer_busy | input | 1 | A transfer is in progress |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| ctrl_wr | input | 1 | One-cycle strobe: control register write |
| fault_flag | output | 1 | Latched mode fault |
| irq | output | 1 | Interrupt request |
| sck_oe | output | 1 | Serial clock pad drive enable |
| mosi_oe | output | 1 | MOSI pad drive enable |
| miso_oe | output | 1 | MISO pad drive enable |
| xfer_abort | output | 1 | Abort request to the shifter |

## Verification
Fault detection and the software clear can land on the same clock edge. This happens when select is still asserted in master mode, or still deasserted during a slave transfer, at the moment software completes its read-then-write sequence. The bench provokes this on purpose: it issues the status read and control write while holding select in the faulting state. It then checks that the flag survives, and that it does fall on a later clear once the pad is released. A reference model built from queues compares every output on every clock, including during a long randomized phase in which strobes, role and pad level change freely.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } spi_role_e;

    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
    } pad_dir_t;

    typedef struct packed {
        logic slave_deselect;
        logic master_contend;
    } fault_cause_t;

    localparam logic SSEL_IDLE = 1'b1;

    function automatic pad_dir_t role_dirs(spi_role_e role, logic release_drv);
        pad_dir_t d;
        if (role == ROLE_MASTER) begin
            d.sck  = ~release_drv;
            d.mosi = ~release_drv;
            d.miso = 1'b0;
        end else begin
            d.sck  = 1'b0;
            d.mosi = 1'b0;
            d.miso = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/sfg_sync.sv
module sfg_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sfg_detect.sv
module sfg_detect
    import spi_fault_pkg::*;
(
    input  spi_role_e    role,
    input  logic         fault_en,
    input  logic         ssel_sync,
    input  logic         xfer_busy,
    output fault_cause_t cause,
    output logic         set_req
);
    always_comb begin
        cause.slave_deselect = (role == ROLE_SLAVE)  && xfer_busy && (ssel_sync == SSEL_IDLE);
        cause.master_contend = (role == ROLE_MASTER) && (ssel_sync != SSEL_IDLE);
        set_req = fault_en && (cause.slave_deselect || cause.master_contend);
    end
endmodule

// File: rtl/sfg_flag.sv
module sfg_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic stat_rd,
    input  logic ctrl_wr,
    output logic flag
);
    logic flag_q, flag_n;
    logic armed_q, armed_n;
    logic clr;

    always_comb begin
        clr    = ctrl_wr && armed_q;
        flag_n = set_req || (flag_q && !clr);
        if (ctrl_wr)                 armed_n = 1'b0;
        else if (stat_rd && flag_q)  armed_n = 1'b1;
        else                         armed_n = armed_q;
        if (!flag_n) armed_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_n;
            armed_q <= armed_n;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/sfg_pins.sv
module sfg_pins
    import spi_fault_pkg::*;
(
    input  spi_role_e role,
    input  logic      flag,
    output logic      sck_oe,
    output logic      mosi_oe,
    output logic      miso_oe,
    output logic      abort
);
    pad_dir_t dirs;

    always_comb begin
        dirs    = role_dirs(role, flag);
        sck_oe  = dirs.sck;
        mosi_oe = dirs.mosi;
        miso_oe = dirs.miso;
        abort   = (role == ROLE_MASTER) && flag;
    end
endmodule

// File: rtl/spi_fault_guard.sv
module spi_fault_guard
    import spi_fault_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic master_sel,
    input  logic fault_en,
    input  logic irq_en,
    input  logic ssel_pin,
    input  logic xfer_busy,
    input  logic stat_rd,
    input  logic ctrl_wr,
    output logic fault_flag,
    output logic irq,
    output logic sck_oe,
    output logic mosi_oe,
    output logic miso_oe,
    output logic xfer_abort
);
    spi_role_e    role;
    logic         ssel_s;
    fault_cause_t cause;
    logic         set_req;
    logic         flag;

    assign role = master_sel ? ROLE_MASTER : ROLE_SLAVE;

    sfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(SSEL_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d_async(ssel_pin), .q_sync(ssel_s)
    );

    sfg_detect u_detect (
        .role(role), .fault_en(fault_en), .ssel_sync(ssel_s),
        .xfer_busy(xfer_busy), .cause(cause), .set_req(set_req)
    );

    sfg_flag u_flag (
        .clk(clk), .rst(rst), .set_req(set_req),
        .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .flag(flag)
    );

    sfg_pins u_pins (
        .role(role), .flag(flag), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
        .miso_oe(miso_oe), .abort(xfer_abort)
    );

    assign fault_flag = flag;
    assign irq        = flag && irq_en;
endmodule

// File: rtl/spi_fault_guard_chk.sv
module spi_fault_guard_chk (
    input logic clk,
    input logic rst,
    input logic master_sel,
    input logic fault_en,
    input logic irq_en,
    input logic ctrl_wr,
    input logic fault_flag,
    input logic irq,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe,
    input logic xfer_abort
);
    p_oe_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(mosi_oe && miso_oe));

    p_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!fault_en && !fault_flag) |=> !fault_flag);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !ctrl_wr) |=> fault_flag);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && master_sel) |-> (!sck_oe && !mosi_oe && xfer_abort));

    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |-> (fault_flag && master_sel));

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (fault_flag && irq_en));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> !fault_flag);
endmodule

bind spi_fault_guard spi_fault_guard_chk u_chk (.*);

// File: tb/test_spi_fault_guard.sv
module test_spi_fault_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_sel = 1'b0, fault_en = 1'b0, irq_en = 1'b0;
    logic ssel_pin = 1'b1, xfer_busy = 1'b0, stat_rd = 1'b0, ctrl_wr = 1'b0;
    logic fault_flag, irq, sck_oe, mosi_oe, miso_oe, xfer_abort;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference state
    bit m_flag = 0;
    bit m_read_seen = 0;
    bit pad_hist[$];

    always #10 clk = ~clk;

    spi_fault_guard i_spi_fault_guard (.*);

    // behavioural model: update at each edge from inputs stable since negedge
    always @(posedge clk) begin
        bit seen, fault, clear_ok;
        if (rst) begin
            m_flag = 0;
            m_read_seen = 0;
            pad_hist.delete();
        end else begin
            seen = (pad_hist.size() >= 2) ? pad_hist[1] : 1'b1; // R10, R11
            fault = fault_en && (master_sel ? !seen : (xfer_busy && seen)); // R2 R3 R4
            clear_ok = ctrl_wr && m_read_seen;                             // R6
            if (ctrl_wr) m_read_seen = 0;
            else if (stat_rd && m_flag) m_read_seen = 1;
            if (fault) m_flag = 1;                                        // R7
            else if (clear_ok) m_flag = 0;
            if (!m_flag) m_read_seen = 0;
            pad_hist.push_front(ssel_pin);
            if (pad_hist.size() > 2) void'(pad_hist.pop_back());
        end
    end

    task automatic cmp(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("R2 R3 R5 R6 R7 fault_flag", fault_flag, m_flag);
        cmp("R9 irq", irq, m_flag && irq_en);
        cmp("R1 R8 sck_oe", sck_oe, master_sel && !m_flag);
        cmp("R1 R8 mosi_oe", mosi_oe, master_sel && !m_flag);
        cmp("R1 miso_oe", miso_oe, !master_sel);
        cmp("R8 xfer_abort", xfer_abort, master_sel && m_flag);
    endtask

    // check outputs, then apply next inputs, all at negedge
    task automatic step(input logic ms, en, ie, ss, busy, rd, wr);
        @(negedge clk);
        if (!rst) compare_all();
        master_sel = ms; fault_en = en; irq_en = ie;
        ssel_pin = ss; xfer_busy = busy; stat_rd = rd; ctrl_wr = wr;
    endtask

    task automatic hold(input int n, input logic ms, en, ie, ss, busy);
        for (int i = 0; i < n; i++) step(ms, en, ie, ss, busy, 1'b0, 1'b0);
    endtask

    task automatic sw_clear(input logic ms, en, ie, ss, busy);
        step(ms, en, ie, ss, busy, 1'b1, 1'b0);
        step(ms, en, ie, ss, busy, 1'b0, 1'b1);
        step(ms, en, ie, ss, busy, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state, slave idle
        hold(4, 0, 1, 1, 1, 0);
        // R1 slave: selected and busy, no fault
        hold(4, 0, 1, 1, 0, 1);
        // R2 R11: deselect during transfer, flag after two sync flops
        hold(5, 0, 1, 1, 1, 1);
        // R6: write without read does not clear
        step(0, 1, 1, 0, 0, 0, 1);
        hold(2, 0, 1, 1, 0, 0);
        // R6: read then write clears
        sw_clear(0, 1, 1, 0, 0);
        hold(3, 0, 1, 0, 0, 0);
        // R1 master, idle pad high
        hold(4, 1, 1, 1, 1, 0);
        // R3 R8 R9: select low in master mode, no transfer
        hold(5, 1, 1, 1, 0, 0);
        hold(2, 1, 1, 0, 0, 0);
        // R7: clear while pad still low -> stays set
        sw_clear(1, 1, 1, 0, 0);
        hold(2, 1, 1, 1, 0, 0);
        // release pad, then clear
        hold(4, 1, 1, 1, 1, 0);
        sw_clear(1, 1, 1, 1, 0);
        hold(3, 1, 1, 1, 1, 0);
        // R4: disabled detector, master contention, no set
        hold(6, 1, 0, 1, 0, 1);
        hold(4, 1, 0, 1, 1, 0);
        // R5: set, then drop enable: flag held; clear; stays clear
        hold(5, 1, 1, 1, 0, 0);
        hold(3, 1, 0, 1, 0, 0);
        sw_clear(1, 0, 1, 0, 0);
        hold(5, 1, 0, 1, 0, 0);
        // R7 in slave mode
        hold(4, 0, 1, 1, 1, 1);
        sw_clear(0, 1, 1, 1, 1);
        hold(2, 0, 1, 1, 0, 0);
        // randomized phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[0] ^ r[7], $urandom_range(0, 7) != 0, r[2], r[3] | r[6], r[4],
                 $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
        end
        step(0, 0, 0, 1, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule